// File: doc/BRIEF.md
# Ring-Counter Pair Random Bit Generator

The block builds a random word from a bank of racing ring pairs. Each lane holds a 16-bit circulating shift register that is loaded with a single 1. The ring rotates by one position each time its own step input is asserted. A counter next to each ring counts how often a 1 wraps from the top position back into position 0. Two lanes form a pair. When the generation window closes, a comparator reduces each pair's two tallies to one output bit. With the default of 128 pairs side by side, a full 128-bit word comes out of each run.

A small controller sequences a run through three named states:
- ST_IDLE: waiting, with the rings held.
- ST_RUN: the window is open and the rings step while the enable is high.
- ST_CMP: one cycle in which the tallies are compared and the word is registered.

The controller takes these transitions:
- ST_IDLE to ST_RUN on a start pulse.
- ST_RUN to ST_CMP once the last enabled window cycle has been counted.
- ST_CMP to ST_IDLE unconditionally.
- Any state to ST_RUN on a start pulse, which clears and reloads every lane.

In silicon the step inputs come from free-running oscillation sources. In simulation the testbench drives them at chosen rates.

Top module: `rcpair_rng`

## Requirements
- R1: After reset, `valid` is 0 and `word` is all zeros.
- R2: A `start` pulse clears every wrap counter, loads every ring with the pattern INIT_PAT (default 16'h0001, a single 1 in position 0), restarts the window and enters ST_RUN. A ring rotates towards higher positions, and a wrap event is counted on each step taken while the top position holds a 1. With the default pattern, a ring that has taken s steps therefore shows floor(s/16) events.
- R3: No wrap counter ever exceeds the window length, so counts never wrap around.
- R4: Bit i of `word` is 1 when the first ring of pair i (`step_a[i]`) has strictly more wrap events than the second ring (`step_b[i]`). A tie or a smaller count gives 0.
- R5: The window is RING_W*RING_W (default 256) cycles in ST_RUN with `enable` high, and the step inputs are sampled in exactly those cycles. The cycle after the last window cycle is ST_CMP. On the following cycle `valid` is 1 for exactly one cycle, and `word` carries the new result.
- R6: While `enable` is low, the rings, the counters and the window timer all hold, step inputs are ignored, and no `valid` pulse appears. The run resumes where it stopped.
- R7: A `start` pulse during ST_RUN abandons the current window and begins a fresh one from cleared counters.
- R8: `word` holds its value from one `valid` pulse to the next.
- R9: Each output bit depends only on its own pair's step inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | High lets rings step and the window advance |
| start | input | 1 | One-cycle pulse that reloads the rings and opens a window |
| step_a | input | NPAIRS | Step strobes of the first ring of each pair |
| step_b | input | NPAIRS | Step strobes of the second ring of each pair |
| valid | output | 1 | One-cycle pulse marking a new word |
| word | output | NPAIRS | Registered comparison result, one bit per pair |

## Verification
The hardest situation to reach from the ports is a pair whose two tallies sit right at a 16-step wrap boundary. In that case one extra or one missing step flips the output bit, and a tie has to resolve to 0. The stimulus reaches it by letting each ring step on every cycle up to its own per-lane cutoff. The cutoffs are spread across the 128 lanes, so many pairs land just above, just below or exactly on a boundary within one window. Separate runs stop the window with long disabled stretches while the steps stay high, and restart it mid-window. A behavioural model tracks every lane's step count and the window position and compares `valid` and `word` on every clock.

// File: rtl/rcpr_pkg.sv
package rcpr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CMP  = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/ring_lane.sv
module ring_lane #(
    parameter int              RING_W   = 16,
    parameter logic [RING_W-1:0] INIT_PAT = 16'h0001,
    parameter int              MAX_EV   = 256,
    parameter int              CW       = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    output logic [CW-1:0] count
);
    logic [RING_W-1:0] ring;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring  <= INIT_PAT;
            count <= '0;
        end else if (load) begin
            ring  <= INIT_PAT;
            count <= '0;
        end else if (adv) begin
            ring <= {ring[RING_W-2:0], ring[RING_W-1]};
            if (ring[RING_W-1]) begin
                count <= count + 1'b1;
            end
        end
    end

    // R6: without load or advance the lane is frozen
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> ($stable(ring) && $stable(count)));

    // R2: load clears the tally
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == '0));

    // R3: the tally never exceeds the window length
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(MAX_EV));

    // R2: the tally changes by at most one per cycle unless cleared
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

// File: rtl/lane_pair.sv
module lane_pair #(
    parameter int                RING_W   = 16,
    parameter logic [RING_W-1:0] INIT_PAT = 16'h0001,
    parameter int                MAX_EV   = 256,
    parameter int                CW       = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run_en,
    input  logic step_a,
    input  logic step_b,
    output logic a_wins
);
    logic [CW-1:0] cnt_a;
    logic [CW-1:0] cnt_b;

    ring_lane #(.RING_W(RING_W), .INIT_PAT(INIT_PAT), .MAX_EV(MAX_EV), .CW(CW)) u_lane_a (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (run_en & step_a),
        .count (cnt_a)
    );

    ring_lane #(.RING_W(RING_W), .INIT_PAT(INIT_PAT), .MAX_EV(MAX_EV), .CW(CW)) u_lane_b (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (run_en & step_b),
        .count (cnt_b)
    );

    // R4: strict greater-than, tie gives 0
    always_comb begin
        a_wins = (cnt_a > cnt_b);
    end
endmodule

// File: rtl/window_ctrl.sv
module window_ctrl
    import rcpr_pkg::*;
#(
    parameter int WINDOW = 256,
    parameter int WW     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    output logic load,
    output logic run_en,
    output logic capture
);
    ctl_state_t state, state_nx;
    logic [WW-1:0] wcnt;
    logic          last_cyc;

    always_comb begin
        last_cyc = (wcnt == WW'(WINDOW - 1));
    end

    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_RUN:  if (enable && last_cyc) state_nx = ST_CMP;
                ST_CMP:  state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            wcnt  <= '0;
        end else begin
            state <= state_nx;
            if (start) begin
                wcnt <= '0;
            end else if (state == ST_RUN && enable && !last_cyc) begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

    always_comb begin
        load    = start;
        run_en  = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  run_en  = enable && !start;
            ST_CMP:  capture = !start;
            default: ;
        endcase
    end

    // R5: the compare cycle lasts one cycle
    p_capture_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);

    // R6: disabled run cycles hold the window position
    p_window_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !enable && !start) |=> (state == ST_RUN && $stable(wcnt)));

    // R7: a start always opens a fresh window
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_RUN && wcnt == '0));
endmodule

// File: rtl/rcpair_rng.sv
module rcpair_rng #(
    parameter int                NPAIRS   = 128,
    parameter int                RING_W   = 16,
    parameter logic [RING_W-1:0] INIT_PAT = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [NPAIRS-1:0] step_a,
    input  logic [NPAIRS-1:0] step_b,
    output logic              valid,
    output logic [NPAIRS-1:0] word
);
    localparam int WINDOW = RING_W * RING_W;
    localparam int CW     = $clog2(WINDOW + 1);
    localparam int WW     = $clog2(WINDOW);

    logic              load;
    logic              run_en;
    logic              capture;
    logic [NPAIRS-1:0] wins;

    window_ctrl #(.WINDOW(WINDOW), .WW(WW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .start   (start),
        .load    (load),
        .run_en  (run_en),
        .capture (capture)
    );

    for (genvar g = 0; g < NPAIRS; g++) begin : g_pair
        lane_pair #(.RING_W(RING_W), .INIT_PAT(INIT_PAT), .MAX_EV(WINDOW), .CW(CW)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .run_en (run_en),
            .step_a (step_a[g]),
            .step_b (step_b[g]),
            .a_wins (wins[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            word  <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                word <= wins;
            end
        end
    end

    // R8: the word only changes together with a valid pulse
    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(word));

    // R5: valid is a single-cycle pulse
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6: no result is produced while the block is disabled
    p_no_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !$past(enable) && !$past(enable, 2)) |-> !valid);
endmodule

// File: tb/tb_rcpair_rng.sv
module tb_rcpair_rng;
    localparam int NP   = 128;
    localparam int RW   = 16;
    localparam int WIN  = RW * RW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          start = 1'b0;
    logic [NP-1:0] step_a = '0;
    logic [NP-1:0] step_b = '0;
    logic          valid;
    logic [NP-1:0] word;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    rcpair_rng #(.NPAIRS(NP), .RING_W(RW), .INIT_PAT(16'h0001)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .start  (start),
        .step_a (step_a),
        .step_b (step_b),
        .valid  (valid),
        .word   (word)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model
    int            m_state = 0;   // 0 idle, 1 run, 2 compare
    int            m_pos   = 0;
    int            ma [NP];
    int            mb [NP];
    logic          exp_valid = 1'b0;
    logic [NP-1:0] exp_word  = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state   = 0;
            m_pos     = 0;
            exp_valid = 1'b0;
            exp_word  = '0;
            for (int i = 0; i < NP; i++) begin ma[i] = 0; mb[i] = 0; end
        end else begin
            exp_valid = 1'b0;
            if (start) begin
                m_state = 1;
                m_pos   = 0;
                for (int i = 0; i < NP; i++) begin ma[i] = 0; mb[i] = 0; end
            end else if (m_state == 1) begin
                if (enable) begin
                    for (int i = 0; i < NP; i++) begin
                        ma[i] += int'(step_a[i]);
                        mb[i] += int'(step_b[i]);
                    end
                    if (m_pos == WIN - 1) m_state = 2;
                    else m_pos++;
                end
            end else if (m_state == 2) begin
                for (int i = 0; i < NP; i++) exp_word[i] = ((ma[i] / RW) > (mb[i] / RW));
                exp_valid = 1'b1;
                m_state   = 0;
            end
        end
    end

    task automatic check_now(string req);
        n_checks++;
        if (valid !== exp_valid || word !== exp_word) begin
            n_fail++;
            $display("FAIL %s: valid=%b word=%h expected valid=%b word=%h",
                     req, valid, word, exp_valid, exp_word);
        end
    endtask

    task automatic tick(logic en, logic st, logic [NP-1:0] sa, logic [NP-1:0] sb);
        @(negedge clk);
        check_now(cur_req);
        enable = en;
        start  = st;
        step_a = sa;
        step_b = sb;
    endtask

    function automatic void pattern(int mode, int k, output logic [NP-1:0] sa,
                                    output logic [NP-1:0] sb);
        for (int i = 0; i < NP; i++) begin
            case (mode)
                0: begin
                    sa[i] = (i % 2 == 0) ? 1'b1 : (k % 2 == 0);
                    sb[i] = (i % 2 == 0) ? (k % 2 == 0) : 1'b1;
                end
                1: begin
                    sa[i] = (k % 3 == 0);
                    sb[i] = (k % 3 == 0);
                end
                2: begin
                    sa[i] = (k < WIN - i);
                    sb[i] = (k < WIN - ((i * 37) % 200));
                end
                default: begin
                    sa[i] = ((k + i) % 5 != 0);
                    sb[i] = ((k * 7 + i) % 4 != 0);
                end
            endcase
        end
    endfunction

    task automatic run_window(int mode, int gap_every);
        logic [NP-1:0] sa, sb;
        tick(1'b1, 1'b1, '0, '0);
        for (int k = 0; k < WIN; k++) begin
            if (gap_every > 0 && k % gap_every == 3) begin
                tick(1'b0, 1'b0, '1, '1);
                tick(1'b0, 1'b0, '1, '0);
            end
            pattern(mode, k, sa, sb);
            tick(1'b1, 1'b0, sa, sb);
        end
        for (int k = 0; k < 4; k++) tick(1'b1, 1'b0, '0, '0);
    endtask

    task automatic expect_word(string req, logic [NP-1:0] want);
        @(negedge clk);
        n_checks++;
        if (word !== want) begin
            n_fail++;
            $display("FAIL %s: word=%h expected %h", req, word, want);
        end
    endtask

    initial begin
        logic [NP-1:0] alt;
        for (int i = 0; i < NP; i++) alt[i] = (i % 2 == 0);

        repeat (3) @(negedge clk);
        cur_req = "R1";
        n_checks++;
        if (valid !== 1'b0 || word !== '0) begin
            n_fail++;
            $display("FAIL R1: valid=%b word=%h expected 0 and 0", valid, word);
        end
        rst_n = 1'b1;
        repeat (3) tick(1'b0, 1'b0, '0, '0);

        cur_req = "R9";
        run_window(0, 0);
        expect_word("R9", alt);

        cur_req = "R4";
        run_window(1, 0);
        expect_word("R4", '0);

        cur_req = "R2";
        run_window(2, 0);

        cur_req = "R3";
        run_window(3, 0);

        cur_req = "R6";
        run_window(3, 17);
        tick(1'b1, 1'b1, '0, '0);
        for (int k = 0; k < 100; k++) tick(1'b1, 1'b0, '1, '0);
        for (int k = 0; k < 300; k++) begin
            tick(1'b0, 1'b0, '1, '1);
            n_checks++;
            if (valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R6: valid=%b expected 0", valid);
            end
        end
        for (int k = 0; k < WIN - 100 + 4; k++) tick(1'b1, 1'b0, '0, '1);

        cur_req = "R7";
        tick(1'b1, 1'b1, '0, '0);
        for (int k = 0; k < 120; k++) tick(1'b1, 1'b0, '0, '1);
        run_window(0, 0);

        cur_req = "R8";
        for (int k = 0; k < 50; k++) tick(1'b1, 1'b0, '1, '0);

        cur_req = "R5";
        run_window(2, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule